// File: doc/BRIEF.md
# CPU Run/Halt/Sleep Power Controller

This block holds the CPU power state and drives the clock enables that come from it. From RUN, a halt command stops only the CPU clock: the high-speed oscillator and the peripheral clock keep going, so timers go on counting. A sleep command stops the CPU clock, switches the high-speed oscillator off and gates the low-speed clock to the divider and peripherals. The low-speed clock that drives this block is never gated.

Each low-power state has its own wake sources. HALT ends on any hardware interrupt request: the maskable interrupt request, the non-maskable request, or a qualified input-port interrupt. SLEEP ends only on a qualified input-port interrupt. A port qualifies when its raw interrupt, its select bit, its enable bit and its filter-bypass bit are all high and the global interrupt enable is set. This test is pure gating with no clocked filter, because the filter clocks are stopped during SLEEP. After a port wake, the oscillator comes back on and a stabilisation counter runs on the low-speed clock before the CPU clock is enabled again. A one-cycle resume pulse marks the first RUN cycle after any wake.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset the state is RUN, with cpu_clk_en, hosc_en and periph_clk_en at 1 and resume_pulse at 0.
- R2: A cmd_halt pulse in RUN clears cpu_clk_en from the next cycle on. hosc_en and periph_clk_en stay at 1.
- R3: In HALT, irq_any, nmi or a qualified port wake sets cpu_clk_en back to 1 in the next cycle.
- R4: A cmd_sleep pulse in RUN clears cpu_clk_en, hosc_en and periph_clk_en in the next cycle. If cmd_halt and cmd_sleep arrive together, sleep wins.
- R5: In SLEEP, irq_any and nmi have no effect, and all three enables stay at 0.
- R6: A port i wakes the block only when port_irq[i], port_sel[i], port_en[i], port_nf_byp[i] and gie are all 1. If any of these is 0, the block stays asleep. A single-cycle request is enough to wake it.
- R7: In the cycle after a port wake from SLEEP, hosc_en and periph_clk_en return to 1. cpu_clk_en then stays 0 for exactly stab_tc+1 cycles, counted from that cycle, and rises afterwards.
- R8: resume_pulse is 1 for exactly one cycle: the first cycle of RUN after HALT or after the stabilisation wait.
- R9: cmd_halt and cmd_sleep have no effect in HALT, in SLEEP and during the stabilisation wait.
- R10: stab_tc is captured when the port wake occurs. Changing it during the wait does not alter the wait length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed clock, never gated |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_halt | input | 1 | Halt command pulse |
| cmd_sleep | input | 1 | Sleep command pulse |
| irq_any | input | 1 | Any maskable hardware interrupt request |
| nmi | input | 1 | Non-maskable interrupt request |
| gie | input | 1 | Global interrupt enable |
| port_irq | input | N_PORT | Raw input-port interrupt factors |
| port_sel | input | N_PORT | Per-port interrupt select |
| port_en | input | N_PORT | Per-port interrupt enable (mask) |
| port_nf_byp | input | N_PORT | Per-port noise filter bypassed |
| stab_tc | input | STAB_W | Stabilisation terminal count |
| cpu_clk_en | output | 1 | CPU clock enable |
| hosc_en | output | 1 | High-speed oscillator enable |
| periph_clk_en | output | 1 | Low-speed clock enable to divider and peripherals |
| resume_pulse | output | 1 | One-cycle pulse on return to RUN |

## Verification
The bench tries every port with every one of the 32 settings of its five wake-qualifier bits while the block is asleep. Only the all-ones setting may turn the oscillator back on, which separates a correct AND of the qualifiers from a design that drops one of them. A sweep of stab_tc over its full 4-bit range, with the low cycles counted in the bench, catches off-by-one errors in the wait. Wakes from HALT by each of its three sources, sleep attempts with irq_any and nmi, commands given in every non-RUN state, and a terminal-count change during the wait each isolate one rule of the state machine.

// File: rtl/pwr_ctrl_pkg.sv
package pwr_ctrl_pkg;

  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_HALT  = 2'd1,
    PS_SLEEP = 2'd2,
    PS_STAB  = 2'd3
  } pwr_state_t;

  // cycles spent waiting for the oscillator for a given terminal count
  function automatic int unsigned stab_span(input int unsigned tc);
    return tc + 1;
  endfunction

  // a state keeps the oscillator on unless it is deep sleep
  function automatic logic osc_needed(input pwr_state_t s);
    return (s != PS_SLEEP);
  endfunction

endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
  parameter int N_PORT = 4
) (
  input  logic              gie,
  input  logic [N_PORT-1:0] port_irq,
  input  logic [N_PORT-1:0] port_sel,
  input  logic [N_PORT-1:0] port_en,
  input  logic [N_PORT-1:0] port_nf_byp,
  output logic              port_wake
);

  logic [N_PORT-1:0] hit;

  // pure gating per port: no clocked filter stage in the wake path
  generate
    for (genvar i = 0; i < N_PORT; i++) begin : g_port
      assign hit[i] = port_irq[i] & port_sel[i] & port_en[i] & port_nf_byp[i];
    end
  endgenerate

  assign port_wake = gie & (|hit);

endmodule

// File: rtl/pwr_stab_timer.sv
module pwr_stab_timer #(
  parameter int STAB_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic [STAB_W-1:0] tc_in,
  output logic              done
);

  logic [STAB_W-1:0] cnt;
  logic [STAB_W-1:0] tc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tc_q <= '0;
    end else if (start) begin
      cnt  <= '0;
      tc_q <= tc_in;
    end else if (run && !done) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = run && (cnt == tc_q);

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= tc_q));

  // R10
  tc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start) |=> (start || $stable(tc_q)));

endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_halt,
  input  logic       cmd_sleep,
  input  logic       irq_any,
  input  logic       nmi,
  input  logic       port_wake,
  input  logic       stab_done,
  output pwr_state_t state,
  output logic       stab_start,
  output logic       cpu_clk_en,
  output logic       hosc_en,
  output logic       periph_clk_en,
  output logic       resume_pulse
);

  pwr_state_t nxt;
  logic       halt_wake;

  assign halt_wake  = irq_any | nmi | port_wake;
  assign stab_start = (state == PS_SLEEP) && port_wake;

  always_comb begin
    nxt = state;
    case (state)
      PS_RUN: begin
        if (cmd_sleep)     nxt = PS_SLEEP;
        else if (cmd_halt) nxt = PS_HALT;
      end
      PS_HALT:  if (halt_wake) nxt = PS_RUN;
      PS_SLEEP: if (port_wake) nxt = PS_STAB;
      PS_STAB:  if (stab_done) nxt = PS_RUN;
      default:  nxt = PS_RUN;
    endcase
  end

  // enables registered from the next state so they change with it, glitch free
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= PS_RUN;
      cpu_clk_en    <= 1'b1;
      hosc_en       <= 1'b1;
      periph_clk_en <= 1'b1;
      resume_pulse  <= 1'b0;
    end else begin
      state         <= nxt;
      cpu_clk_en    <= (nxt == PS_RUN);
      hosc_en       <= osc_needed(nxt);
      periph_clk_en <= osc_needed(nxt);
      resume_pulse  <= (state != PS_RUN) && (nxt == PS_RUN);
    end
  end

  // R2
  en_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en == (state == PS_RUN));

  // R3
  halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_HALT && halt_wake) |=> (state == PS_RUN && resume_pulse));

  // R5
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_SLEEP && !port_wake) |=> (state == PS_SLEEP));

  // R8
  resume_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !resume_pulse);

  // R4
  sleep_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_RUN && cmd_sleep) |=> (state == PS_SLEEP && !hosc_en));

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_ctrl_pkg::*;
#(
  parameter int N_PORT = 4,
  parameter int STAB_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_halt,
  input  logic              cmd_sleep,
  input  logic              irq_any,
  input  logic              nmi,
  input  logic              gie,
  input  logic [N_PORT-1:0] port_irq,
  input  logic [N_PORT-1:0] port_sel,
  input  logic [N_PORT-1:0] port_en,
  input  logic [N_PORT-1:0] port_nf_byp,
  input  logic [STAB_W-1:0] stab_tc,
  output logic              cpu_clk_en,
  output logic              hosc_en,
  output logic              periph_clk_en,
  output logic              resume_pulse
);

  pwr_state_t state;
  logic       port_wake;
  logic       stab_start;
  logic       stab_done;
  logic       stab_run;

  assign stab_run = (state == PS_STAB);

  pwr_wake_qual #(.N_PORT(N_PORT)) u_qual (
    .gie         (gie),
    .port_irq    (port_irq),
    .port_sel    (port_sel),
    .port_en     (port_en),
    .port_nf_byp (port_nf_byp),
    .port_wake   (port_wake)
  );

  pwr_stab_timer #(.STAB_W(STAB_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (stab_start),
    .run   (stab_run),
    .tc_in (stab_tc),
    .done  (stab_done)
  );

  pwr_state_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_halt      (cmd_halt),
    .cmd_sleep     (cmd_sleep),
    .irq_any       (irq_any),
    .nmi           (nmi),
    .port_wake     (port_wake),
    .stab_done     (stab_done),
    .state         (state),
    .stab_start    (stab_start),
    .cpu_clk_en    (cpu_clk_en),
    .hosc_en       (hosc_en),
    .periph_clk_en (periph_clk_en),
    .resume_pulse  (resume_pulse)
  );

  // R7
  stab_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stab_done |=> (cpu_clk_en && resume_pulse));

  // R6
  sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stab_start |=> (hosc_en && periph_clk_en && !cpu_clk_en));

endmodule

// File: tb/test_pwr_sleep_ctrl.sv
module test_pwr_sleep_ctrl;

  localparam int NP = 4;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_halt = 0, cmd_sleep = 0, irq_any = 0, nmi = 0, gie = 0;
  logic [NP-1:0] port_irq = '0, port_sel = '0, port_en = '0, port_nf_byp = '0;
  logic [SW-1:0] stab_tc = '0;
  logic          cpu_clk_en, hosc_en, periph_clk_en, resume_pulse;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pwr_sleep_ctrl #(.N_PORT(NP), .STAB_W(SW)) i_pwr_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_halt(cmd_halt), .cmd_sleep(cmd_sleep),
    .irq_any(irq_any), .nmi(nmi), .gie(gie), .port_irq(port_irq),
    .port_sel(port_sel), .port_en(port_en), .port_nf_byp(port_nf_byp),
    .stab_tc(stab_tc), .cpu_clk_en(cpu_clk_en), .hosc_en(hosc_en),
    .periph_clk_en(periph_clk_en), .resume_pulse(resume_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // one clock: inputs and samples sit 5 ns after the rising edge
  task automatic cyc();
    @(posedge clk);
    #5;
  endtask

  function automatic int enables();
    return {29'd0, cpu_clk_en, hosc_en, periph_clk_en};
  endfunction

  task automatic go_sleep();
    cmd_sleep = 1; cyc(); cmd_sleep = 0;
  endtask

  task automatic go_halt();
    cmd_halt = 1; cyc(); cmd_halt = 0;
  endtask

  task automatic wake_port(input int p);
    gie = 1; port_sel[p] = 1; port_en[p] = 1; port_nf_byp[p] = 1; port_irq[p] = 1;
    cyc();
    gie = 0; port_sel = '0; port_en = '0; port_nf_byp = '0; port_irq = '0;
  endtask

  task automatic wait_run();
    for (int k = 0; k < 40 && !cpu_clk_en; k++) cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #25 rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 enables", enables(), 7);
    chk("R1 resume", resume_pulse, 0);

    // R2 halt keeps oscillator and peripherals
    go_halt();
    chk("R2 halt enables", enables(), 3);
    // R9 commands ignored in HALT
    cmd_sleep = 1; cyc(); cmd_sleep = 0;
    chk("R9 sleep in halt", enables(), 3);
    // R3 wake by irq_any, R8 pulse width
    irq_any = 1; cyc(); irq_any = 0;
    chk("R3 irq wake", cpu_clk_en, 1);
    chk("R8 resume high", resume_pulse, 1);
    cyc();
    chk("R8 resume low", resume_pulse, 0);
    // R3 wake by nmi and by port
    go_halt(); nmi = 1; cyc(); nmi = 0;
    chk("R3 nmi wake", cpu_clk_en, 1);
    go_halt(); wake_port(2);
    chk("R3 port wake", cpu_clk_en, 1);

    // R4 sleep wins over halt
    cmd_halt = 1; cmd_sleep = 1; cyc(); cmd_halt = 0; cmd_sleep = 0;
    chk("R4 sleep enables", enables(), 0);
    // R5 irq and nmi ignored in sleep
    irq_any = 1; nmi = 1; cyc(); cyc(); irq_any = 0; nmi = 0;
    chk("R5 sleep hold", enables(), 0);
    // R9 halt ignored in sleep
    cmd_halt = 1; cyc(); cmd_halt = 0;
    chk("R9 halt in sleep", enables(), 0);
    stab_tc = 3;
    wake_port(1);
    chk("R7 osc back", enables(), 3);
    // R9 commands ignored during the wait
    cmd_sleep = 1; cmd_halt = 1; cyc(); cmd_sleep = 0; cmd_halt = 0;
    chk("R9 cmd in wait", enables(), 3);
    wait_run();
    chk("R9 back to run", cpu_clk_en, 1);

    // R6 qualifier sweep over every port and every qualifier pattern
    stab_tc = 0;
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 32; m++) begin
        go_sleep();
        gie = m[0]; port_sel[p] = m[1]; port_en[p] = m[2];
        port_nf_byp[p] = m[3]; port_irq[p] = m[4];
        cyc();
        gie = 0; port_sel = '0; port_en = '0; port_nf_byp = '0; port_irq = '0;
        chk($sformatf("R6 port%0d pat%0d", p, m), hosc_en, (m == 31) ? 1 : 0);
        if (!hosc_en) wake_port(p);
        wait_run();
        cyc();
      end
    end

    // R7 wait length sweep, counted from the first cycle after the wake
    for (int tc = 0; tc < 16; tc++) begin
      int cnt;
      stab_tc = tc[SW-1:0];
      go_sleep();
      wake_port(tc % NP);
      cnt = 0;
      for (int k = 0; k < 40 && !cpu_clk_en; k++) begin
        cnt++;
        cyc();
      end
      chk($sformatf("R7 wait tc=%0d", tc), cnt, tc + 1);
      chk("R8 resume after wait", resume_pulse, 1);
      cyc();
      chk("R8 resume drop", resume_pulse, 0);
    end

    // R10 terminal count held once the wait has begun
    stab_tc = 5;
    go_sleep();
    wake_port(0);
    stab_tc = 0;
    begin
      int cnt;
      cnt = 0;
      for (int k = 0; k < 40 && !cpu_clk_en; k++) begin
        cnt++;
        cyc();
      end
      chk("R10 captured tc", cnt, 6);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule